// File: doc/BRIEF.md
# Display refresh clock generator

This block turns a choice of oscillator into the display clock enable of a multiplexed dot-matrix driver. It also keeps the position inside the refresh cycle. Both oscillators arrive as single-cycle tick strobes in the block's clock domain. One is the on-chip oscillator and the other comes from outside. A select input chooses between them. When the outside source is chosen, an optional divide-by-8 can slow it down. The on-chip source is never divided.

Each display clock enable advances a 9-bit refresh position. A full refresh is 512 display clocks, so with the divider active it is 4096 outside ticks. A one-cycle end-of-frame pulse marks the wrap back to zero.

In a chain of displays, one device is the master. It forwards its chosen oscillator tick on an output pin. The other devices select that pin as their outside source.

Top module: `disp_clk_gen`

## Requirements
- R1: With `use_ext_osc`=1 and `presc_en`=0, every high `ext_osc_tick` makes `disp_clk_en` high for exactly the following cycle, and `int_osc_tick` has no effect.
- R2: With `use_ext_osc`=1 and `presc_en`=1, `disp_clk_en` goes high for one cycle only after every eighth `ext_osc_tick`, counted from the last restart of the divider.
- R3: With `use_ext_osc`=0, every high `int_osc_tick` makes `disp_clk_en` high the following cycle, whatever the value of `presc_en`, and `ext_osc_tick` has no effect.
- R4: `refresh_pos` is a 9-bit value. It rises by one in the cycle after each `disp_clk_en` pulse, holds otherwise, and wraps from 511 to 0.
- R5: `frame_end` is high for exactly one cycle, the cycle in which `refresh_pos` has just wrapped from 511 to 0. With the divider active, one frame therefore spans 4096 outside ticks.
- R6: The divider is active when `use_ext_osc` and `presc_en` are both 1. In any cycle where that condition differs from the previous cycle, the divide count restarts at zero and `disp_clk_en` is low in the next cycle.
- R7: With `is_master`=1, `osc_fwd_out` equals the selected source tick in the same cycle, before any division. With `is_master`=0 it is held at 0.
- R8: While `rst_n` is low at a clock edge, the divide count, `disp_clk_en`, `refresh_pos` and `frame_end` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all tick strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_osc_tick | input | 1 | One-cycle strobe from the outside (or master) oscillator |
| int_osc_tick | input | 1 | One-cycle strobe from the on-chip oscillator |
| use_ext_osc | input | 1 | 1 selects the outside oscillator, 0 the on-chip one |
| presc_en | input | 1 | 1 divides the outside oscillator by 8 |
| is_master | input | 1 | 1 forwards the selected oscillator on `osc_fwd_out` |
| osc_fwd_out | output | 1 | Forwarded oscillator tick for slave devices |
| disp_clk_en | output | 1 | Display clock enable, one cycle per display clock |
| refresh_pos | output | 9 | Position within the 512-step refresh cycle |
| frame_end | output | 1 | One-cycle pulse on refresh wrap |

## Verification
Outside ticks on every cycle, with the divider both off and on, separate pass-through from divide-by-8. Each of those runs lasts a full frame, so the wrap and the end-of-frame pulse are reached. Sparse, irregular tick patterns on both oscillators show that the unselected source is ignored. The same patterns show that the divider counts ticks, not cycles. Toggling the divide bit and the source select part-way through a count, and asserting reset mid-frame, distinguish a true restart from a count that carries on.

// File: rtl/disp_clk_pkg.sv
// Package: shared defaults for the display clock generator.
// Assumes: the divide ratio is a power of two, at least 2.
package disp_clk_pkg;
    localparam int unsigned POS_W_DEF = 9;    // refresh position width
    localparam int unsigned DIV_DEF   = 8;    // outside oscillator divide ratio
endpackage

// File: rtl/osc_src_mux.sv
// osc_src_mux: picks the oscillator tick stream and decides whether the
// divider applies. Also drives the forwarded oscillator pin.
// Assumes: ticks are single-cycle strobes in the clk domain.
module osc_src_mux (
    input  logic use_ext,
    input  logic presc,
    input  logic master,
    input  logic ext_tick,
    input  logic int_tick,
    output logic src_tick,
    output logic div_active,
    output logic fwd_tick
);
    // Source choice, divider qualification and forwarding.
    always_comb begin
        src_tick   = use_ext ? ext_tick : int_tick;
        div_active = use_ext & presc;
        fwd_tick   = master & src_tick;
    end
endmodule

// File: rtl/presc_div.sv
// presc_div: converts source ticks into display clock enables, either
// one-to-one or one per DIV ticks. Restarts the count whenever the
// divide condition changes, so no short period is produced.
// Assumes: DIV is a power of two >= 2.
module presc_div #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic div_active,
    output logic en_out
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mode_q;
    logic          mode_chg;

    assign mode_chg = div_active != mode_q;

    // Remember the divide condition of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= div_active;
    end

    // Tick counter: restarts on mode change, idles in pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg || !div_active) cnt_q <= '0;
        else if (tick)                         cnt_q <= cnt_q + 1'b1;
    end

    // Enable output: one pulse per tick, or per DIV ticks when dividing.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) en_out <= 1'b0;
        else if (div_active)    en_out <= tick && (cnt_q == LAST);
        else                    en_out <= tick;
    end
endmodule

// File: rtl/refresh_ctr.sv
// refresh_ctr: position within the refresh cycle, advanced by the display
// clock enable, with a one-cycle pulse on wrap.
// Assumes: frame length is 2**POS_W so wrap is the natural overflow.
module refresh_ctr #(
    parameter int unsigned POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    // Position counter advanced by each display clock.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (step) pos <= pos + 1'b1;
    end

    // Wrap pulse, aligned with the position returning to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap <= 1'b0;
        else        wrap <= step && (pos == POS_MAX);
    end
endmodule

// File: rtl/disp_clk_gen.sv
// disp_clk_gen: top of the display refresh clock generator. Selects the
// oscillator, optionally divides the outside one, and tracks refresh position.
// Assumes: oscillator inputs are synchronous single-cycle strobes.
module disp_clk_gen
    import disp_clk_pkg::*;
#(
    parameter int unsigned POS_W = POS_W_DEF,
    parameter int unsigned DIV   = DIV_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_osc_tick,
    input  logic             int_osc_tick,
    input  logic             use_ext_osc,
    input  logic             presc_en,
    input  logic             is_master,
    output logic             osc_fwd_out,
    output logic             disp_clk_en,
    output logic [POS_W-1:0] refresh_pos,
    output logic             frame_end
);
    logic src_tick;
    logic div_active;

    osc_src_mux u_mux (
        .use_ext    (use_ext_osc),
        .presc      (presc_en),
        .master     (is_master),
        .ext_tick   (ext_osc_tick),
        .int_tick   (int_osc_tick),
        .src_tick   (src_tick),
        .div_active (div_active),
        .fwd_tick   (osc_fwd_out)
    );

    presc_div #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (src_tick),
        .div_active (div_active),
        .en_out     (disp_clk_en)
    );

    refresh_ctr #(.POS_W(POS_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (disp_clk_en),
        .pos   (refresh_pos),
        .wrap  (frame_end)
    );
endmodule

// File: rtl/disp_clk_gen_chk.sv
// disp_clk_gen_chk: protocol checks on the generator's ports, bound to
// every instance of disp_clk_gen.
module disp_clk_gen_chk #(
    parameter int unsigned POS_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             use_ext_osc,
    input logic             presc_en,
    input logic             is_master,
    input logic             osc_fwd_out,
    input logic             disp_clk_en,
    input logic [POS_W-1:0] refresh_pos,
    input logic             frame_end
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_clk_en |=> refresh_pos == POS_W'($past(refresh_pos) + 1'b1));
    // R4
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_clk_en |=> $stable(refresh_pos));
    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (refresh_pos == '0) && ($past(refresh_pos) == POS_MAX));
    // R5
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    // R6
    mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((use_ext_osc & presc_en) != $past(use_ext_osc & presc_en)) |=> !disp_clk_en);
    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !osc_fwd_out);
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (refresh_pos == '0) && !disp_clk_en && !frame_end);
endmodule

bind disp_clk_gen disp_clk_gen_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_ext_osc (use_ext_osc),
    .presc_en    (presc_en),
    .is_master   (is_master),
    .osc_fwd_out (osc_fwd_out),
    .disp_clk_en (disp_clk_en),
    .refresh_pos (refresh_pos),
    .frame_end   (frame_end)
);

// File: tb/sim_disp_clk_gen.sv
module sim_disp_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_osc_tick = 1'b0;
    logic       int_osc_tick = 1'b0;
    logic       use_ext_osc = 1'b0;
    logic       presc_en = 1'b0;
    logic       is_master = 1'b0;
    logic       osc_fwd_out;
    logic       disp_clk_en;
    logic [8:0] refresh_pos;
    logic       frame_end;

    always #2 clk = ~clk;   // 250 MHz

    disp_clk_gen u0 (.*);

    typedef struct {
        logic       en;
        logic [8:0] pos;
        logic       eof;
        logic       fwd;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    string cur_req = "R8";

    // Requirement model state
    logic [2:0] m_cnt = 0;
    logic       m_modeq = 0, m_en = 0, m_eof = 0;
    logic [8:0] m_pos = 0;
    int         eof_seen = 0;

    task automatic chk1(string what, string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: apply inputs for one cycle and push the expected post-edge values.
    task automatic step(bit ext, bit intk, bit sel, bit pre, bit mst, bit rst);
        logic eff, tk;
        exp_t e;
        @(negedge clk);
        ext_osc_tick = ext; int_osc_tick = intk; use_ext_osc = sel;
        presc_en = pre; is_master = mst; rst_n = rst;
        eff = sel & pre;
        tk  = sel ? ext : intk;
        if (!rst) begin
            m_cnt = 0; m_modeq = 0; m_en = 0; m_pos = 0; m_eof = 0;
        end else begin
            m_eof = m_en && (m_pos == 9'd511);           // R5
            if (m_en) m_pos = m_pos + 9'd1;              // R4
            if (eff != m_modeq) begin                    // R6
                m_cnt = 0; m_en = 0;
            end else if (eff) begin                      // R2
                m_en = tk && (m_cnt == 3'd7);
                if (tk) m_cnt = m_cnt + 3'd1;
            end else begin                               // R1, R3
                m_en = tk; m_cnt = 0;
            end
            m_modeq = eff;
        end
        e.en = m_en; e.pos = m_pos; e.eof = m_eof;
        e.fwd = mst & tk;                                // R7
        e.req = cur_req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs to the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk1("disp_clk_en", e.req, disp_clk_en, e.en);
                chk1("refresh_pos", e.req, refresh_pos, e.pos);
                chk1("frame_end",   e.req, frame_end, e.eof);
                chk1("osc_fwd_out", e.req, osc_fwd_out, e.fwd);
                if (frame_end) eof_seen++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ef0;
        // R8 reset state
        cur_req = "R8";
        repeat (3) step(1, 1, 1, 0, 1, 0);
        // R1 outside source direct, full frame so R4/R5 wrap is reached
        cur_req = "R1";
        for (int i = 0; i < 40; i++) step((i % 3) != 0, i[0], 1, 0, 1, 1);
        cur_req = "R5";
        ef0 = eof_seen;
        for (int i = 0; i < 540; i++) step(1, 0, 1, 0, 0, 1);
        step(0, 0, 1, 0, 0, 1); step(0, 0, 1, 0, 0, 1);
        chk1("frame count direct", "R5", eof_seen - ef0, 1);
        // R3 on-chip source, divide bit ignored
        cur_req = "R3";
        for (int i = 0; i < 40; i++) step(1, (i % 4) != 1, 0, i[1], 1, 1);
        // R2 divided outside source with sparse ticks
        cur_req = "R2";
        for (int i = 0; i < 80; i++) step((i % 3) != 2, 1, 1, 1, 1, 1);
        // R6 toggle divide bit mid-count, then source select
        cur_req = "R6";
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 0, 1);
        step(1, 0, 1, 0, 0, 1);
        step(1, 0, 1, 1, 0, 1);
        for (int i = 0; i < 10; i++) step(1, 0, 1, 1, 0, 1);
        step(1, 1, 0, 1, 0, 1);
        step(1, 1, 1, 1, 0, 1);
        for (int i = 0; i < 12; i++) step(1, 0, 1, 1, 0, 1);
        // R5 a divided frame spans 4096 outside ticks
        cur_req = "R5";
        step(0, 0, 1, 1, 0, 0);
        ef0 = eof_seen;
        for (int i = 0; i < 4100; i++) step(1, 0, 1, 1, 0, 1);
        step(0, 0, 1, 1, 0, 1); step(0, 0, 1, 1, 0, 1);
        chk1("frame count divided", "R5", eof_seen - ef0, 1);
        // R7 forwarding as master, silent as slave
        cur_req = "R7";
        for (int i = 0; i < 16; i++) step(i[0], i[1], i[2], 0, i[3], 1);
        // R8 mid-frame reset
        cur_req = "R8";
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 1, 1);
        step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 1);
        step(0, 0, 1, 0, 1, 1);
        step(0, 0, 1, 0, 1, 1);
        wait (exp_q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule